// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Unit

This block holds the status byte of a serial NOR flash and rules on every modifying command that reaches it after decoding. Each command arrives as a one-cycle strobe, together with a target address, the byte proposed by a status-write command, and the level of the active-low write-protect pin. The block answers each program, erase or status-write command with a one-cycle accept or reject pulse. An accepted command starts a busy interval whose length in clock cycles depends on the command type.

A command is accepted only when the write-enable latch is set and nothing else forbids it. The block-protect level guards the top of the array against program and erase. Chip erase has its own rule. The status-write-disable bit together with a low protect pin locks the status byte against writes. A status read can be started at any time. Once started, it produces the live status byte at a fixed spacing until the chip select goes high.

Top module: `sflash_status_guard`

## Requirements
- R1: After reset the status byte is 0x3C. Its bit fields are: bit7 status-write lock enable, bit6 quad mode, bits 5:2 protect level (bit5 most significant), bit1 write-enable latch, bit0 busy flag.
- R2: Outside a busy interval, `cmd_wren` sets status bit1 and `cmd_wrdi` clears it. Neither strobe produces an accept or reject pulse.
- R3: A program, erase or status-write strobe issued while status bit1 is 0 is rejected, and the status byte stays unchanged.
- R4: A protect level n in 1..15 guards the highest 2^(n-1) blocks of 2^BLK_SHIFT bytes, capped at the whole array. Level 0 guards nothing. A program, sector erase, 32KB erase or block erase whose address falls in a guarded block is rejected, and bit1 keeps its value.
- R5: Chip erase is accepted only when status bits 4:2 are all zero. Bit5 does not affect it.
- R6: When bit7 is 1, bit6 is 0 and `wp_n` is 0, a status-write strobe is rejected and bits 7:2 keep their value.
- R7: When bit6 is 1, a low `wp_n` does not block a status write.
- R8: An accepted command holds bit0 at 1 for exactly its configured number of cycles, starting in the cycle after the strobe. When it completes, bit1 is cleared. For a status write, bits 7:2 take the proposed byte's bits 7:2 at completion.
- R9: While bit0 is 1, every program, erase or status-write strobe is rejected, and `cmd_wren` and `cmd_wrdi` have no effect.
- R10: `op_accept` or `op_reject` pulses for exactly one cycle, in the cycle after a program, erase or status-write strobe. The two are never high together.
- R11: `rd_valid` is high in the cycle after `cmd_rdsr` and then once every RD_GAP cycles, with `rd_data` equal to the status byte of that cycle. It stays low from the cycle after `sel_n` is sampled high, and `sel_n` takes priority over `cmd_rdsr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write-protect pin level, active low |
| sel_n | input | 1 | Chip select level; high ends a status read |
| cmd_wren | input | 1 | Set-write-enable strobe |
| cmd_wrdi | input | 1 | Clear-write-enable strobe |
| cmd_rdsr | input | 1 | Start-status-read strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be32 | input | 1 | 32KB-erase strobe |
| cmd_be | input | 1 | Block-erase strobe |
| cmd_ce | input | 1 | Chip-erase strobe |
| addr | input | ADDR_W | Target address of program or erase |
| wrsr_data | input | 8 | Proposed status byte |
| status | output | 8 | Current status byte |
| op_accept | output | 1 | Command accepted pulse |
| op_reject | output | 1 | Command rejected pulse |
| rd_valid | output | 1 | Status-read byte strobe |
| rd_data | output | 8 | Status byte delivered by the read |

## Verification
The properties assume that the command strobes are mutually exclusive in any cycle and that no strobe is raised while reset is asserted. The acceptance properties also rely on `wp_n` being sampled in the same cycle as the status-write strobe it qualifies. The stimulus drives at most one strobe per cycle on the falling clock edge, holds every strobe low during reset, and changes `wp_n` only together with a strobe.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRSR,
        OP_PP,
        OP_SE,
        OP_B32,
        OP_BE,
        OP_CE
    } op_e;

    typedef struct packed {
        logic       srwd;
        logic       qe;
        logic [3:0] bp;
        logic       wel;
    } ctl_t;

    localparam ctl_t CTL_RST = '{srwd: 1'b0, qe: 1'b0, bp: 4'hF, wel: 1'b0};

endpackage

// File: rtl/sfs_region_check.sv
module sfs_region_check #(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 16
) (
    input  logic [3:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int IDX_W = ADDR_W - BLK_SHIFT;
    localparam logic [31:0] NBLK = 32'd1 << IDX_W;

    logic [31:0] span;
    logic [31:0] blk;
    logic [31:0] lvl_m1;

    always_comb begin
        lvl_m1 = {28'd0, level} - 32'd1;
        blk    = {{(32-IDX_W){1'b0}}, addr[ADDR_W-1:BLK_SHIFT]};
        if (level == 4'd0) begin
            span = 32'd0;
        end else if (lvl_m1 >= 32'(IDX_W)) begin
            span = NBLK;
        end else begin
            span = 32'd1 << lvl_m1;
        end
        hit = (span != 32'd0) && (blk >= (NBLK - span));
    end
endmodule

// File: rtl/sfs_busy_timer.sv
module sfs_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_val;
        end else if (st_q.busy && st_q.cnt == '0) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);
endmodule

// File: rtl/sfs_read_stream.sv
module sfs_read_stream #(
    parameter int GAP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic [7:0] live,
    output logic       valid,
    output logic [7:0] data
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [GW-1:0] LAST = GW'(GAP - 1);

    typedef struct packed {
        logic          act;
        logic [GW-1:0] cnt;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop) begin
            st_d.act = 1'b0;
        end else if (start) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.act) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.act && (st_q.cnt == '0);
    assign data  = live;
endmodule

// File: rtl/sflash_status_guard.sv
module sflash_status_guard
    import sfs_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BLK_SHIFT = 16,
    parameter int T_WRSR    = 6,
    parameter int T_PP      = 8,
    parameter int T_SE      = 10,
    parameter int T_B32     = 12,
    parameter int T_BE      = 14,
    parameter int T_CE      = 20,
    parameter int RD_GAP    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              sel_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_rdsr,
    input  logic              cmd_wrsr,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be32,
    input  logic              cmd_be,
    input  logic              cmd_ce,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wrsr_data,
    output logic [7:0]        status,
    output logic              op_accept,
    output logic              op_reject,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int T_MAX_A = (T_WRSR > T_PP) ? T_WRSR : T_PP;
    localparam int T_MAX_B = (T_SE > T_B32) ? T_SE : T_B32;
    localparam int T_MAX_C = (T_BE > T_CE) ? T_BE : T_CE;
    localparam int T_MAX_D = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int T_MAX   = (T_MAX_C > T_MAX_D) ? T_MAX_C : T_MAX_D;
    localparam int CNT_W   = $clog2(T_MAX) + 1;

    typedef struct packed {
        ctl_t       ctl;
        logic [5:0] pend;
        logic       pend_en;
        logic       acc;
        logic       rej;
    } state_t;

    state_t st_d, st_q;

    op_e              op;
    logic             busy, done, prot_hit, hw_lock, allowed, load;
    logic [CNT_W-1:0] load_val;

    sfs_region_check #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_region (
        .level (st_q.ctl.bp),
        .addr  (addr),
        .hit   (prot_hit)
    );

    sfs_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .busy     (busy),
        .done     (done)
    );

    sfs_read_stream #(.GAP(RD_GAP)) u_read (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd_rdsr),
        .stop  (sel_n),
        .live  (status),
        .valid (rd_valid),
        .data  (rd_data)
    );

    always_comb begin
        if      (cmd_wrsr) op = OP_WRSR;
        else if (cmd_pp)   op = OP_PP;
        else if (cmd_se)   op = OP_SE;
        else if (cmd_be32) op = OP_B32;
        else if (cmd_be)   op = OP_BE;
        else if (cmd_ce)   op = OP_CE;
        else               op = OP_NONE;
    end

    always_comb begin
        hw_lock  = st_q.ctl.srwd && !wp_n && !st_q.ctl.qe;
        allowed  = 1'b0;
        load_val = '0;
        unique case (op)
            OP_WRSR: begin allowed = !hw_lock;                 load_val = CNT_W'(T_WRSR - 1); end
            OP_PP:   begin allowed = !prot_hit;                load_val = CNT_W'(T_PP - 1);   end
            OP_SE:   begin allowed = !prot_hit;                load_val = CNT_W'(T_SE - 1);   end
            OP_B32:  begin allowed = !prot_hit;                load_val = CNT_W'(T_B32 - 1);  end
            OP_BE:   begin allowed = !prot_hit;                load_val = CNT_W'(T_BE - 1);   end
            OP_CE:   begin allowed = (st_q.ctl.bp[2:0] == 3'b000); load_val = CNT_W'(T_CE - 1); end
            default: begin allowed = 1'b0;                     load_val = '0;                 end
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.acc = 1'b0;
        st_d.rej = 1'b0;
        load     = 1'b0;
        if (op != OP_NONE) begin
            if (!busy && st_q.ctl.wel && allowed) begin
                st_d.acc = 1'b1;
                load     = 1'b1;
                if (op == OP_WRSR) begin
                    st_d.pend    = wrsr_data[7:2];
                    st_d.pend_en = 1'b1;
                end
            end else begin
                st_d.rej = 1'b1;
            end
        end else if (!busy) begin
            if (cmd_wren)      st_d.ctl.wel = 1'b1;
            else if (cmd_wrdi) st_d.ctl.wel = 1'b0;
        end
        if (done) begin
            st_d.ctl.wel = 1'b0;
            if (st_q.pend_en) begin
                st_d.ctl.srwd = st_q.pend[5];
                st_d.ctl.qe   = st_q.pend[4];
                st_d.ctl.bp   = st_q.pend[3:0];
                st_d.pend_en  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctl: CTL_RST, pend: 6'd0, pend_en: 1'b0, acc: 1'b0, rej: 1'b0};
        else        st_q <= st_d;
    end

    assign status    = {st_q.ctl, busy};
    assign op_accept = st_q.acc;
    assign op_reject = st_q.rej;
endmodule

// File: rtl/sfs_status_guard_chk.sv
module sfs_status_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic       sel_n,
    input logic       cmd_wrsr,
    input logic       cmd_ce,
    input logic [7:0] status,
    input logic       op_accept,
    input logic       op_reject,
    input logic       rd_valid
);
    p_accept_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_accept |-> $past(status[1]));

    p_accept_raises_wip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_accept |-> status[0]);

    p_done_clears_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_accept |-> !$past(status[0]));

    p_ce_needs_low_bp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_accept && $past(cmd_ce)) |-> ($past(status[4:2]) == 3'b000));

    p_hw_lock_rejects_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cmd_wrsr && status[7] && !status[6] && !wp_n) |-> op_reject);

    p_acc_rej_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_accept && op_reject));

    p_read_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sel_n) |-> !rd_valid);
endmodule

bind sflash_status_guard sfs_status_guard_chk u_chk (.*);

// File: tb/sflash_status_guard_test.sv
module sflash_status_guard_test;
    localparam int ADDR_W = 20;
    localparam int T_SE   = 10;
    localparam int RD_GAP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1, sel_n = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_rdsr = 0, cmd_wrsr = 0;
    logic cmd_pp = 0, cmd_se = 0, cmd_be32 = 0, cmd_be = 0, cmd_ce = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wrsr_data = '0;
    logic [7:0] status, rd_data;
    logic op_accept, op_reject, rd_valid;

    int checks = 0;
    int errors = 0;
    logic got_acc, got_rej;

    always #5 clk = ~clk;

    sflash_status_guard uut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .sel_n(sel_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_rdsr(cmd_rdsr),
        .cmd_wrsr(cmd_wrsr), .cmd_pp(cmd_pp), .cmd_se(cmd_se),
        .cmd_be32(cmd_be32), .cmd_be(cmd_be), .cmd_ce(cmd_ce),
        .addr(addr), .wrsr_data(wrsr_data), .status(status),
        .op_accept(op_accept), .op_reject(op_reject),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // op codes: 1 set-enable, 2 clear-enable, 3 status write, 4 program,
    // 5 sector erase, 6 32KB erase, 7 block erase, 8 chip erase
    typedef struct packed {
        logic [3:0]  op;
        logic [19:0] a;
        logic [7:0]  d;
        logic        wp;
        logic        acc;
        logic        rej;
        logic [7:0]  st;
    } vec_t;

    localparam vec_t TBL [30] = '{
        '{4'd4, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3C}, // R3 latch clear
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h3E}, // R2
        '{4'd4, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h3E}, // R4 level 15
        '{4'd2, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h3C}, // R2
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h3E},
        '{4'd3, 20'h00000, 8'h0C, 1'b1, 1'b1, 1'b0, 8'h0C}, // level 3
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h0E},
        '{4'd4, 20'hC0000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0E}, // R4 block 12 guarded
        '{4'd4, 20'hBFFFF, 8'h00, 1'b1, 1'b1, 1'b0, 8'h0C}, // R4 block 11 free
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h0E},
        '{4'd8, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h0E}, // R5 low bits nonzero
        '{4'd3, 20'h00000, 8'h20, 1'b1, 1'b1, 1'b0, 8'h20}, // level 8, capped
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h22},
        '{4'd8, 20'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h20}, // R5 bit5 ignored
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h22},
        '{4'd5, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b1, 8'h22}, // R4 whole array
        '{4'd3, 20'h00000, 8'h80, 1'b1, 1'b1, 1'b0, 8'h80},
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h82},
        '{4'd3, 20'h00000, 8'h3C, 1'b0, 1'b0, 1'b1, 8'h82}, // R6 lock
        '{4'd3, 20'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00},
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'h02},
        '{4'd3, 20'h00000, 8'hC0, 1'b1, 1'b1, 1'b0, 8'hC0},
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC2},
        '{4'd3, 20'h00000, 8'hC4, 1'b0, 1'b1, 1'b0, 8'hC4}, // R7 quad bypass
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC6},
        '{4'd7, 20'hF0000, 8'h00, 1'b1, 1'b0, 1'b1, 8'hC6}, // R4 level 1
        '{4'd6, 20'hE8000, 8'h00, 1'b1, 1'b1, 1'b0, 8'hC4},
        '{4'd1, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC6},
        '{4'd5, 20'h00000, 8'h00, 1'b1, 1'b1, 1'b0, 8'hC4},
        '{4'd2, 20'h00000, 8'h00, 1'b1, 1'b0, 1'b0, 8'hC4}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [19:0] a,
                         input logic [7:0] d, input logic wp);
        @(negedge clk);
        addr = a; wrsr_data = d; wp_n = wp;
        cmd_wren = (op == 4'd1); cmd_wrdi = (op == 4'd2);
        cmd_wrsr = (op == 4'd3); cmd_pp   = (op == 4'd4);
        cmd_se   = (op == 4'd5); cmd_be32 = (op == 4'd6);
        cmd_be   = (op == 4'd7); cmd_ce   = (op == 4'd8);
        @(negedge clk);
        got_acc = op_accept; got_rej = op_reject;
        {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be32, cmd_be, cmd_ce} = '0;
        wp_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && status[0]; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", status, 8'h3C);
        check("R10 reset accept", op_accept, 0);
        check("R10 reset reject", op_reject, 0);
        check("R11 reset read", rd_valid, 0);

        for (int v = 0; v < 30; v++) begin
            issue(TBL[v].op, TBL[v].a, TBL[v].d, TBL[v].wp);
            if (TBL[v].op <= 4'd2)                            tag = "R2";
            else if (TBL[v].rej && !TBL[v].st[1])             tag = "R3";
            else if (TBL[v].op == 4'd3 && !TBL[v].wp && TBL[v].acc) tag = "R7";
            else if (TBL[v].op == 4'd3)                       tag = "R6";
            else if (TBL[v].op == 4'd8)                       tag = "R5";
            else                                              tag = "R4";
            check($sformatf("R10 accept vec %0d", v), got_acc, TBL[v].acc);
            check($sformatf("R10 reject vec %0d", v), got_rej, TBL[v].rej);
            wait_idle();
            check($sformatf("%s status vec %0d", tag, v), status, TBL[v].st);
        end

        // R8: busy length of a sector erase
        issue(4'd1, 20'h0, 8'h0, 1'b1);
        issue(4'd5, 20'h0, 8'h0, 1'b1);
        n = 0;
        while (status[0] && n < 200) begin n++; @(negedge clk); end
        check("R8 busy cycles", n, T_SE);
        check("R8 latch cleared", status, 8'hC4);

        // R9: commands during busy
        issue(4'd1, 20'h0, 8'h0, 1'b1);
        issue(4'd4, 20'h0, 8'h0, 1'b1);
        issue(4'd2, 20'h0, 8'h0, 1'b1);
        check("R9 clear ignored while busy", status, 8'hC7);
        issue(4'd4, 20'h0, 8'h0, 1'b1);
        check("R9 program rejected while busy", got_rej, 1);
        check("R9 no accept while busy", got_acc, 0);
        wait_idle();
        check("R9 status after busy", status, 8'hC4);

        // R11: status read during busy
        issue(4'd1, 20'h0, 8'h0, 1'b1);
        issue(4'd4, 20'h0, 8'h0, 1'b1);
        @(negedge clk);
        sel_n = 1'b0; cmd_rdsr = 1'b1;
        @(negedge clk);
        cmd_rdsr = 1'b0;
        check("R11 first strobe", rd_valid, 1);
        check("R11 first byte busy", rd_data, 8'hC7);
        n = 0;
        for (int i = 1; i <= 2 * RD_GAP; i++) begin
            @(negedge clk);
            if (rd_valid) n++;
            if (i == 2 * RD_GAP) begin
                check("R11 strobe at gap", rd_valid, 1);
                check("R11 live byte idle", rd_data, 8'hC4);
            end
        end
        check("R11 strobe count", n, 2);
        sel_n = 1'b1;
        n = 0;
        for (int i = 0; i < 3 * RD_GAP; i++) begin
            @(negedge clk);
            if (rd_valid) n++;
        end
        check("R11 stopped by select", n, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule